// File: doc/BRIEF.md
# Clock-Generator Configuration Write Slave

This block is the serial control port of a clock generator. It watches a two-wire bus (a clock line and an open-drain data line) with a faster system clock, finds start and stop conditions, and accepts only write transfers. Its 7-bit bus address is picked by three strap pins through a fixed, non-linear table. After the address it takes a command byte (only 0x00 is accepted), a byte count, and then data bytes. The data bytes fill three 8-bit configuration registers, beginning with register 0. It acknowledges a byte by pulling the data line low for the ninth clock.

From the register contents and a few board pins the block produces the effective control outputs of the generator. These are the output frequency multiplier select, spread enable, spread width, test mode, reference-output enable and five bank clock enables. A register bit picks whether frequency and spread come from board pins or from register bits. A bank output-enable pin can force all bank clocks off.

Top module: `smb_cfg_slave`

## Requirements
- R1: With strap pins {s2,s1,s0} the expected address byte (7 address bits then write bit 0) is 000→0xDE, 001→0xDC, 010→0xDA, 011→0xD8, 100→0xD6, 101→0xD4, 110→0xD0, 111→0xD2; a matching byte is acknowledged by `sda_pull` going high during the ninth clock.
- R2: An address byte that differs from the expected one, including one with the read bit (LSB) set to 1, is not acknowledged, and nothing else is acknowledged or written until the next start.
- R3: A command byte of 0x00 is acknowledged; any other command value is not acknowledged and the rest of the transfer is ignored.
- R4: The byte-count byte is acknowledged and its value does not limit how many data bytes are written.
- R5: Data bytes are received MSB first and written to registers 0, 1, 2 in that order; a stop after any whole byte keeps the bytes already written.
- R6: Data bytes after the third are acknowledged and leave all registers unchanged.
- R7: After synchronous reset `rst` the registers hold reg0=0xA1, reg1=0xFF, reg2=0xFF.
- R8: When reg0 bit 0 is 1, `freq_sel` equals `hw_freq_sel` and `spread_on` equals the inverse of `hw_spread_n`.
- R9: When reg0 bit 0 is 0, `freq_sel` equals reg0 bits 4:3 and `spread_on` equals reg0 bit 6.
- R10: `spread_half` (0.5 % width when 1, 1.0 % when 0) equals reg0 bit 5, and `test_mode` is 1 exactly when reg0 bit 7 is 0.
- R11: `ref_en` equals reg1 bit 5, and `clk_en[k]` follows reg2 bit k for k = 0..4.
- R12: While `bank_oe` is 0, `clk_en` is all zero whatever reg2 holds.
- R13: A repeated start (data falling while clock high in the middle of a transfer) restarts the sequence at the address byte, so the next data byte goes to register 0 again.
- R14: A stop (data rising while clock high) releases the data line and returns the slave to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_pull | output | 1 | 1 = pull the data line low (acknowledge) |
| strap_addr | input | 3 | Address strap pins {s2,s1,s0} |
| hw_freq_sel | input | 2 | Board pins for frequency multiplier select |
| hw_spread_n | input | 1 | Board pin, spread enabled when low |
| bank_oe | input | 1 | Bank output enable, active high |
| freq_sel | output | 2 | Effective multiplier select (0..3 for x1..x4) |
| spread_on | output | 1 | Effective spread enable |
| spread_half | output | 1 | Spread width 0.5 % when 1, 1.0 % when 0 |
| test_mode | output | 1 | Test mode active |
| ref_en | output | 1 | Reference output enable |
| clk_en | output | 5 | Bank clock enables, bit k for clock k |

## Verification
The bench builds the block with its defaults: three registers, five bank clocks and two synchronizer stages, with the bus clock held for eight system cycles per half period. So the two-stage input delay stays well inside each bus phase. The ninth-clock acknowledge, its release, and the point where a data edge during high clock counts as a start or stop can then be checked at fixed sample points. Using all three registers lets the run write past the last one, cut a transfer short, and restart a transfer in the middle. Several strap settings check the address table.

// File: rtl/smbcfg_pkg.sv
`timescale 1ns/1ps
package smbcfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_IGNORE
    } link_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } byte_phase_e;

    // bit positions inside configuration register 0
    localparam int CR0_SRC_PINS = 0;
    localparam int CR0_FSEL_LO  = 3;
    localparam int CR0_WIDTH    = 5;
    localparam int CR0_SPREAD   = 6;
    localparam int CR0_NORMAL   = 7;
    // bit position inside configuration register 1
    localparam int CR1_REF      = 5;

    localparam logic [7:0] BLOCK_CMD = 8'h00;

    // address byte (write bit included) selected by the strap pins
    function automatic logic [7:0] strap_to_addr(input logic [2:0] strap);
        logic [7:0] a;
        case (strap)
            3'd0:    a = 8'hDE;
            3'd1:    a = 8'hDC;
            3'd2:    a = 8'hDA;
            3'd3:    a = 8'hD8;
            3'd4:    a = 8'hD6;
            3'd5:    a = 8'hD4;
            3'd6:    a = 8'hD0;
            default: a = 8'hD2;
        endcase
        return a;
    endfunction

    function automatic logic [7:0] reg_default(input int idx);
        return (idx == 0) ? 8'hA1 : 8'hFF;
    endfunction

    function automatic byte_phase_e phase_after(input byte_phase_e ph);
        byte_phase_e n;
        case (ph)
            PH_ADDR: n = PH_CMD;
            PH_CMD:  n = PH_CNT;
            default: n = PH_DATA;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/smb_pin_sync.sv
`timescale 1ns/1ps
module smb_pin_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '1;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/smb_byte_engine.sv
`timescale 1ns/1ps
module smb_byte_engine
    import smbcfg_pkg::*;
#(
    parameter int NUM_REGS = 3,
    localparam int IDX_W   = $clog2(NUM_REGS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [2:0]       strap_addr,
    output logic             drive_low,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    typedef struct packed {
        link_state_e      st;
        byte_phase_e      ph;
        logic [7:0]       sh;
        logic [3:0]       bits;
        logic             drv;
        logic [IDX_W-1:0] idx;
        logic             wr;
        logic [IDX_W-1:0] widx;
        logic [7:0]       wdata;
        logic             scl_p;
        logic             sda_p;
    } eng_t;

    eng_t q, d;

    logic start_det, stop_det, scl_rise, scl_fall;
    logic [7:0] own_addr;

    assign start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;
    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign own_addr  = strap_to_addr(strap_addr);

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        d.scl_p = scl_s;
        d.sda_p = sda_s;
        if (start_det) begin
            d.st   = ST_RECV;
            d.ph   = PH_ADDR;
            d.bits = '0;
            d.drv  = 1'b0;
            d.idx  = '0;
        end else if (stop_det) begin
            d.st  = ST_IDLE;
            d.drv = 1'b0;
        end else begin
            case (q.st)
                ST_RECV: begin
                    if (scl_rise && q.bits < 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bits = q.bits + 4'd1;
                    end
                    if (scl_fall && q.bits == 4'd8) begin
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh == own_addr) begin
                                    d.st  = ST_ACK;
                                    d.drv = 1'b1;
                                end else begin
                                    d.st = ST_IGNORE;
                                end
                            end
                            PH_CMD: begin
                                if (q.sh == BLOCK_CMD) begin
                                    d.st  = ST_ACK;
                                    d.drv = 1'b1;
                                end else begin
                                    d.st = ST_IGNORE;
                                end
                            end
                            PH_CNT: begin
                                d.st  = ST_ACK;
                                d.drv = 1'b1;
                            end
                            default: begin
                                d.st  = ST_ACK;
                                d.drv = 1'b1;
                                if (q.idx < IDX_W'(NUM_REGS)) begin
                                    d.wr    = 1'b1;
                                    d.widx  = q.idx;
                                    d.wdata = q.sh;
                                    d.idx   = q.idx + 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_rise) begin
                        d.bits = 4'd9;
                    end else if (scl_fall && q.bits == 4'd9) begin
                        d.drv  = 1'b0;
                        d.st   = ST_RECV;
                        d.bits = '0;
                        d.ph   = phase_after(q.ph);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ph    <= PH_ADDR;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign drive_low = q.drv;
    assign wr_en     = q.wr;
    assign wr_idx    = q.widx;
    assign wr_data   = q.wdata;

    p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE || q.st == ST_IGNORE) |-> !q.drv);
    p_ack_on_low_clock_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(q.drv) |-> !scl_s);
    p_start_rearms_r13: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (q.st == ST_RECV && q.ph == PH_ADDR && q.bits == 4'd0));
    p_stop_frees_line_r14: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !start_det) |=> (!q.drv && q.st == ST_IDLE));
    p_write_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        q.wr |-> (q.widx < IDX_W'(NUM_REGS)));
endmodule

// File: rtl/cfg_bank.sv
`timescale 1ns/1ps
module cfg_bank
    import smbcfg_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int NUM_CLKS = 5,
    localparam int IDX_W   = $clog2(NUM_REGS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_data,
    input  logic [1:0]          hw_freq_sel,
    input  logic                hw_spread_n,
    input  logic                bank_oe,
    output logic [1:0]          freq_sel,
    output logic                spread_on,
    output logic                spread_half,
    output logic                test_mode,
    output logic                ref_en,
    output logic [NUM_CLKS-1:0] clk_en
);
    logic [NUM_REGS-1:0][7:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_default(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    logic pins_rule;
    assign pins_rule   = regs_q[0][CR0_SRC_PINS];
    assign freq_sel    = pins_rule ? hw_freq_sel : regs_q[0][CR0_FSEL_LO +: 2];
    assign spread_on   = pins_rule ? ~hw_spread_n : regs_q[0][CR0_SPREAD];
    assign spread_half = regs_q[0][CR0_WIDTH];
    assign test_mode   = ~regs_q[0][CR0_NORMAL];
    assign ref_en      = regs_q[1][CR1_REF];

    for (genvar g = 0; g < NUM_CLKS; g++) begin : g_clk_gate
        assign clk_en[g] = bank_oe & regs_q[2][g];
    end

    p_oe_blocks_bank_r12: assert property (@(posedge clk) disable iff (rst)
        !bank_oe |-> (clk_en == '0));
    p_hold_without_write_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));
    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx < IDX_W'(NUM_REGS)) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave #(
    parameter int NUM_REGS    = 3,
    parameter int NUM_CLKS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                sda_pull,
    input  logic [2:0]          strap_addr,
    input  logic [1:0]          hw_freq_sel,
    input  logic                hw_spread_n,
    input  logic                bank_oe,
    output logic [1:0]          freq_sel,
    output logic                spread_on,
    output logic                spread_half,
    output logic                test_mode,
    output logic                ref_en,
    output logic [NUM_CLKS-1:0] clk_en
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);

    logic             scl_s, sda_s;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    smb_pin_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_in, sda_in}),
        .dout ({scl_s, sda_s})
    );

    smb_byte_engine #(.NUM_REGS(NUM_REGS)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .strap_addr (strap_addr),
        .drive_low  (sda_pull),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data)
    );

    cfg_bank #(.NUM_REGS(NUM_REGS), .NUM_CLKS(NUM_CLKS)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .hw_freq_sel (hw_freq_sel),
        .hw_spread_n (hw_spread_n),
        .bank_oe     (bank_oe),
        .freq_sel    (freq_sel),
        .spread_on   (spread_on),
        .spread_half (spread_half),
        .test_mode   (test_mode),
        .ref_en      (ref_en),
        .clk_en      (clk_en)
    );
endmodule

// File: tb/smb_cfg_slave_tb.sv
`timescale 1ns/1ps
module smb_cfg_slave_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'd0;
    logic [1:0] hsel = 2'd0;
    logic       hspn = 1'b1;
    logic       oe = 1'b1;
    logic       sda_pull;
    logic [1:0] freq_sel;
    logic       spread_on, spread_half, test_mode, ref_en;
    logic [4:0] clk_en;
    wire        sda_line = sda_m & ~sda_pull;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] m [3];

    always #5 clk = ~clk;

    smb_cfg_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_pull(sda_pull),
        .strap_addr(strap), .hw_freq_sel(hsel), .hw_spread_n(hspn), .bank_oe(oe),
        .freq_sel(freq_sel), .spread_on(spread_on), .spread_half(spread_half),
        .test_mode(test_mode), .ref_en(ref_en), .clk_en(clk_en)
    );

    typedef struct packed {
        logic [2:0]  strap;
        logic [7:0]  addr;
        logic [7:0]  cmd;
        logic [7:0]  cnt;
        logic [2:0]  nd;
        logic [31:0] data;
        logic [1:0]  hsel;
        logic        hspn;
        logic        oe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'hDE, 8'h00, 8'd3, 3'd3, 32'h98DF1500, 2'd1, 1'b0, 1'b1}, // R1 R5 R9 R11
        '{3'd5, 8'hD4, 8'h00, 8'd1, 3'd1, 32'h49000000, 2'd2, 1'b1, 1'b1}, // R8 R10
        '{3'd6, 8'hD0, 8'h00, 8'd2, 3'd2, 32'h60FF0000, 2'd3, 1'b0, 1'b0}, // R12
        '{3'd3, 8'hD6, 8'h00, 8'd2, 3'd2, 32'h00000000, 2'd0, 1'b1, 1'b1}, // R2 mismatch
        '{3'd7, 8'hD2, 8'h05, 8'd2, 3'd2, 32'h11220000, 2'd1, 1'b1, 1'b1}, // R3
        '{3'd1, 8'hDC, 8'h00, 8'd1, 3'd4, 32'hA1FF0A33, 2'd0, 1'b1, 1'b1}, // R4 R6
        '{3'd2, 8'hDA, 8'h00, 8'd3, 3'd0, 32'h00000000, 2'd2, 1'b0, 1'b1}, // R5 stop early
        '{3'd4, 8'hD6, 8'h00, 8'd3, 3'd3, 32'h90201F00, 2'd0, 1'b1, 1'b1}  // R9 R11
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] addr_of(input logic [2:0] s);
        case (s)
            3'd0: return 8'hDE;  3'd1: return 8'hDC;
            3'd2: return 8'hDA;  3'd3: return 8'hD8;
            3'd4: return 8'hD6;  3'd5: return 8'hD4;
            3'd6: return 8'hD0;  default: return 8'hD2;
        endcase
    endfunction

    function automatic logic [10:0] expect_out();
        logic [1:0] fs;
        logic sp;
        fs = m[0][0] ? hsel : m[0][4:3];
        sp = m[0][0] ? ~hspn : m[0][6];
        return {fs, sp, m[0][5], ~m[0][7], m[1][5], (oe ? m[2][4:0] : 5'd0)};
    endfunction

    function automatic logic [10:0] actual_out();
        return {freq_sel, spread_on, spread_half, test_mode, ref_en, clk_en};
    endfunction

    task automatic bus_start();
        scl = 1'b0; tick(4);
        sda_m = 1'b1; tick(4);
        scl = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(4);
        scl = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(4);
            scl = 1'b1; tick(HALF);
            scl = 1'b0; tick(4);
        end
        sda_m = 1'b1; tick(4);
        scl = 1'b1; tick(HALF / 2);
        acked = ~sda_line;
        tick(HALF / 2);
        scl = 1'b0; tick(4);
    endtask

    task automatic reset_model();
        m[0] = 8'hA1; m[1] = 8'hFF; m[2] = 8'hFF;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(5);
        rst = 1'b0; tick(8);
        reset_model();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic ack, live, a_ok;
        reset_model();
        tick(2);
        do_reset();
        // R7: defaults visible through outputs, pins selected by reg0 bit0
        hsel = 2'd2; hspn = 1'b0; tick(2);
        chk("R7 reset outputs", 32'(actual_out()), 32'(expect_out()));
        chk("R7 reset sda idle", 32'(sda_pull), 32'd0);

        for (int v = 0; v < NV; v++) begin
            strap = VECS[v].strap; hsel = VECS[v].hsel;
            hspn = VECS[v].hspn; oe = VECS[v].oe;
            bus_start();
            send_byte(VECS[v].addr, ack);
            a_ok = (VECS[v].addr == addr_of(VECS[v].strap));
            chk("R1 R2 address ack", 32'(ack), 32'(a_ok));
            send_byte(VECS[v].cmd, ack);
            live = a_ok && (VECS[v].cmd == 8'h00);
            chk("R3 command ack", 32'(ack), 32'(live));
            send_byte(VECS[v].cnt, ack);
            chk("R4 count ack", 32'(ack), 32'(live));
            for (int k = 0; k < 4; k++) begin
                if (k < int'(VECS[v].nd)) begin
                    send_byte(VECS[v].data[31-8*k -: 8], ack);
                    chk("R5 R6 data ack", 32'(ack), 32'(live));
                    if (live && k < 3) m[k] = VECS[v].data[31-8*k -: 8];
                end
            end
            bus_stop();
            tick(4);
            chk("R14 line released after stop", 32'(sda_pull), 32'd0);
            chk("R5 R8 R9 R10 R11 R12 outputs", 32'(actual_out()), 32'(expect_out()));
        end

        // R2: read bit set on a matching address is not acknowledged
        strap = 3'd0; oe = 1'b1;
        bus_start();
        send_byte(8'hDF, ack);
        chk("R2 read bit nack", 32'(ack), 32'd0);
        send_byte(8'h00, ack);
        chk("R2 ignored until start", 32'(ack), 32'd0);
        bus_stop(); tick(4);
        chk("R2 registers untouched", 32'(actual_out()), 32'(expect_out()));

        // R13: repeated start restarts at address, data lands in register 0
        bus_start();
        send_byte(8'hDE, ack); send_byte(8'h00, ack); send_byte(8'd3, ack);
        send_byte(8'h81, ack); m[0] = 8'h81;
        bus_start();
        send_byte(8'hDE, ack);
        chk("R13 address ack after repeated start", 32'(ack), 32'd1);
        send_byte(8'h00, ack); send_byte(8'd1, ack);
        send_byte(8'hA0, ack); m[0] = 8'hA0;
        chk("R13 data ack", 32'(ack), 32'd1);
        bus_stop(); tick(4);
        chk("R13 second byte went to register 0", 32'(actual_out()), 32'(expect_out()));

        // R12: dropping bank_oe forces bank enables off
        oe = 1'b0; tick(2);
        chk("R12 bank off", 32'(clk_en), 32'd0);
        oe = 1'b1; tick(2);

        // R7: reset restores defaults after writes
        do_reset();
        hsel = 2'd1; hspn = 1'b1; tick(2);
        chk("R7 defaults restored", 32'(actual_out()), 32'(expect_out()));

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule